// File: doc/BRIEF.md
# Counter-Addressed Feedback Delay Line

This block is the feedback delay element of one stage of a single-path delay-feedback FFT pipeline. It holds complex samples (a real and an imaginary part) and returns each one a fixed number of accepted samples later. A 64-point pipeline uses six copies, with lengths 32, 16, 8, 4, 2 and 1.

Storage never shifts. A wrapping pointer selects one entry of a register bank. On each accepted sample that entry is read toward the output register and then refilled with the new sample. Only the selected entry receives a write enable, so the other entries do not toggle. The output register is one of the `LEN` stages of delay, so the bank holds `LEN-1` entries. With `LEN = 1` the bank and the pointer drop out and only the output register remains.

The stage controller raises `en` on each cycle that carries a sample. Idle cycles freeze the block. The synchronous reset empties it: the output reads zero until the line has filled again.

Top module: `fbk_delay_line`

## Requirements
- R1: On the clock edge after `rst` is sampled high, `dout_re` and `dout_im` are zero.
- R2: Number the edges that see `en` high and `rst` low since the last reset as k = 1, 2, 3, and so on. Just after edge k, with k ≥ `LEN`, `{dout_re, dout_im}` equals the `{din_re, din_im}` sampled at edge k−`LEN`+1.
- R3: Just after each of the first `LEN`−1 accepted edges following a reset, both output parts are zero.
- R4: On an edge where `en` is low, the output keeps its value and the pointer does not move. Idle cycles therefore do not count toward the delay.
- R5: A reset in the middle of a stream discards the stored samples. The fill behaviour of R3 applies again, whatever the bank held before the reset.
- R6: No more than one bank entry has its write enable asserted in any cycle. None is asserted when `en` is low.
- R7: With `LEN = 1`, just after each accepted edge the output equals the input sampled at that same edge.
- R8: The pointer stays below `LEN`−1. It advances by one on each accepted edge and returns to zero after entry `LEN`−2. Delays stay exact across many wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample valid; high accepts `din_*` and advances the line |
| din_re | input | DW | Real part of the incoming sample |
| din_im | input | DW | Imaginary part of the incoming sample |
| dout_re | output | DW | Registered real part of the delayed sample |
| dout_im | output | DW | Registered imaginary part of the delayed sample |

## Verification
Each output change lands on the clock edge that accepts a sample. That is one register after the input, and it reflects the input from `LEN`−1 accepted edges earlier, so the result is due `LEN` accepted samples after its input is first presented. The bench drives inputs on the falling edge. It samples one nanosecond after each rising edge and keeps a history indexed by accepted-edge count, so idle cycles shift nothing in the expected value. All six lengths run side by side on the same stimulus, and each one is compared on every cycle against its own history offset.

// File: rtl/fdl_pkg.sv
package fdl_pkg;

  // Pointer width for a bank of n entries; at least one bit
  function automatic int fdl_ptr_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Width of the one-hot write-select vector; at least one bit
  function automatic int fdl_sel_w(input int n);
    return (n > 0) ? n : 1;
  endfunction

endpackage

// File: rtl/fdl_ptr_ctrl.sv
module fdl_ptr_ctrl #(
  parameter int N  = 31,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [PW-1:0] ptr,
  output logic          primed,
  output logic [N-1:0]  wr_sel
);

  localparam logic [PW-1:0] LAST = PW'(N - 1);

  // Wrapping pointer; primed goes high once every entry holds a real sample
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      primed <= 1'b0;
    end else if (en) begin
      if (ptr == LAST) begin
        ptr    <= '0;
        primed <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // Per-entry gated write enables: only the addressed entry toggles
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign wr_sel[i] = en && (ptr == PW'(i));
  end

endmodule

// File: rtl/fdl_reg_bank.sv
module fdl_reg_bank #(
  parameter int N  = 31,
  parameter int W  = 32,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic [N-1:0]  wr_sel,
  input  logic [PW-1:0] ptr,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] ent [N];

  // Storage carries no reset; the fill flag masks stale contents
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_sel[i]) ent[i] <= din;
    end
  end

  // Read the addressed entry before this edge overwrites it
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (ptr == PW'(i)) rd_data = ent[i];
    end
  end

endmodule

// File: rtl/fdl_out_stage.sv
module fdl_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end

endmodule

// File: rtl/fbk_delay_line.sv
module fbk_delay_line
  import fdl_pkg::*;
#(
  parameter int LEN = 32,
  parameter int DW  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] din_re,
  input  logic [DW-1:0] din_im,
  output logic [DW-1:0] dout_re,
  output logic [DW-1:0] dout_im
);

  localparam int N  = LEN - 1;
  localparam int W  = 2 * DW;
  localparam int PW = fdl_ptr_w(N);
  localparam int SW = fdl_sel_w(N);

  logic [W-1:0]  din_c;
  logic [W-1:0]  nxt;
  logic [W-1:0]  q;
  logic [PW-1:0] ptr;
  logic          primed;
  logic [SW-1:0] wr_sel;

  assign din_c = {din_re, din_im};

  if (N == 0) begin : g_single
    // Length one: the output register alone is the delay
    assign ptr    = '0;
    assign primed = 1'b1;
    assign wr_sel = '0;
    assign nxt    = din_c;
  end else begin : g_bank
    logic [W-1:0] rd_data;

    fdl_ptr_ctrl #(.N(N), .PW(PW)) u_ptr (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .ptr    (ptr),
      .primed (primed),
      .wr_sel (wr_sel)
    );

    fdl_reg_bank #(.N(N), .W(W), .PW(PW)) u_bank (
      .clk     (clk),
      .wr_sel  (wr_sel),
      .ptr     (ptr),
      .din     (din_c),
      .rd_data (rd_data)
    );

    assign nxt = primed ? rd_data : '0;
  end

  fdl_out_stage #(.W(W)) u_out (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .nxt (nxt),
    .q   (q)
  );

  assign dout_re = q[W-1:DW];
  assign dout_im = q[DW-1:0];

endmodule

// File: rtl/fdl_chk.sv
module fdl_chk
  import fdl_pkg::*;
#(
  parameter int LEN = 32,
  parameter int DW  = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     en,
  input logic [DW-1:0]            dout_re,
  input logic [DW-1:0]            dout_im,
  input logic [fdl_ptr_w(LEN-1)-1:0] ptr,
  input logic                     primed,
  input logic [fdl_sel_w(LEN-1)-1:0] wr_sel
);

  localparam int N  = LEN - 1;
  localparam int PW = fdl_ptr_w(N);

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (dout_re == '0 && dout_im == '0))
    else $error("R1 output not cleared by reset");

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> ($stable(dout_re) && $stable(dout_im) && $stable(ptr)))
    else $error("R4 state moved while idle");

  if (N >= 1) begin : g_bank_chk
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    assert_single_write_R6: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wr_sel))
      else $error("R6 several entries enabled");

    assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (rst)
      !en |-> (wr_sel == '0))
      else $error("R6 write while idle");

    assert_fill_zero_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(primed)) |-> (dout_re == '0 && dout_im == '0))
      else $error("R3 data before line filled");

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (rst)
      ptr <= LAST)
      else $error("R8 pointer out of range");

    assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      ($past(en) && !$past(rst) && $past(ptr) == LAST) |-> (ptr == '0))
      else $error("R8 pointer failed to wrap");
  end

endmodule

bind fbk_delay_line fdl_chk #(.LEN(LEN), .DW(DW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .dout_re (dout_re),
  .dout_im (dout_im),
  .ptr     (ptr),
  .primed  (primed),
  .wr_sel  (wr_sel)
);

// File: tb/fbk_delay_line_bench.sv
`timescale 1ns/1ps
module fbk_delay_line_bench;

  localparam int DW = 12;
  localparam int NL = 6;
  localparam int LENS [NL] = '{32, 16, 8, 4, 2, 1};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [DW-1:0] din_re = '0;
  logic [DW-1:0] din_im = '0;
  logic [2*DW-1:0] dout_all [NL];

  int checks = 0;
  int fails  = 0;
  int nacc   = 0;
  logic [2*DW-1:0] hist [0:4095];

  always #10 clk = ~clk;

  for (genvar g = 0; g < NL; g++) begin : g_len
    logic [DW-1:0] o_re, o_im;
    fbk_delay_line #(.LEN(LENS[g]), .DW(DW)) u_fbk_delay_line (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .din_re  (din_re),
      .din_im  (din_im),
      .dout_re (o_re),
      .dout_im (o_im)
    );
    assign dout_all[g] = {o_re, o_im};
  end

  task automatic check(input string tag, input int len,
                       input logic [2*DW-1:0] act, input logic [2*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s LEN=%0d actual=%h expected=%h", tag, len, act, exp);
    end
  endtask

  // Reset for two cycles, then check all outputs are zero (R1)
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'($urandom);
    din_re = DW'($urandom);
    din_im = DW'($urandom);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    en  = 1'b0;
    nacc = 0;
    for (int i = 0; i < NL; i++) check("R1", LENS[i], dout_all[i], '0);
  endtask

  // One cycle of stimulus, then compare every length against the history
  task automatic step(input logic e, input string data_tag, input string fill_tag);
    logic [2*DW-1:0] d;
    @(negedge clk);
    d = {DW'($urandom), DW'($urandom)};
    en = e;
    {din_re, din_im} = d;
    @(posedge clk);
    #1;
    if (e) begin
      nacc++;
      hist[nacc] = d;
    end
    for (int i = 0; i < NL; i++) begin
      logic [2*DW-1:0] exp;
      string tag;
      exp = (nacc >= LENS[i]) ? hist[nacc - LENS[i] + 1] : '0;
      if (!e)                 tag = "R4";
      else if (LENS[i] == 1)  tag = "R7";
      else if (nacc < LENS[i]) tag = fill_tag;
      else                    tag = data_tag;
      check(tag, LENS[i], dout_all[i], exp);
    end
  endtask

  task automatic test_continuous();
    for (int n = 0; n < 80; n++) step(1'b1, "R2", "R3");
  endtask

  task automatic test_wraps();
    for (int n = 0; n < 120; n++) step(1'b1, "R8", "R3");
  endtask

  task automatic test_gaps();
    for (int n = 0; n < 300; n++) step(($urandom % 10) < 6, "R6", "R3");
  endtask

  task automatic test_idle();
    for (int n = 0; n < 10; n++) step(1'b1, "R2", "R3");
    for (int n = 0; n < 40; n++) step(1'b0, "R4", "R4");
    for (int n = 0; n < 40; n++) step(1'b1, "R4", "R3");
  endtask

  task automatic test_midreset();
    do_reset();
    for (int n = 0; n < 60; n++) step(($urandom % 4) != 0, "R2", "R5");
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    test_continuous();
    test_wraps();
    test_gaps();
    test_idle();
    test_midreset();
    test_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule